// File: doc/BRIEF.md
# Tiled Integer Matrix Multiply Engine

This block multiplies two square signed-integer matrices that live in an external word-addressed memory and writes the product back to the same memory. All three matrices are stored row-major. Element (r,c) of a matrix at base address B sits at B + r*W + c, where W is the matrix width. The width and the three base addresses are sampled when a start pulse is accepted. The run then proceeds with no further input until a one-cycle done pulse.

The product is built one TILE x TILE output tile at a time. The tiles are visited in row-major order of tile coordinates. For each output tile the engine runs ceil(W/TILE) phases. Each phase has a load step and a compute step. The load step copies one left-operand tile and one right-operand tile into two local register buffers. Source positions at or past W are written as zero and are never read from memory. A barrier separates loading from computing. In the compute step every accumulator of the tile adds TILE products in TILE cycles. After the last phase the in-range results are written out one per cycle. Because of the zero fill, widths that are not a multiple of TILE still give exact results.

Memory reads return data on the cycle after the request. At most one read or one write is issued in any cycle.

Top module: `tile_matmul_engine`

## Requirements
- R1: Each written value equals the sum over k < W of M[r][k]*N[k][c], signed and exact in ACC_W bits. This holds for W a multiple of TILE, W below TILE, and W between multiples, across several output tiles.
- R2: Left-operand reads use address base_m + r*W + k and right-operand reads use base_n + k*W + c. No read falls outside the W*W words of either operand.
- R3: A tile position whose source row or column is >= W is filled with zero and is not read from memory. The total number of reads per run therefore equals the number of in-range source elements over all phases.
- R4: No multiply-accumulate of a phase happens while a tile element of that phase is still being captured. Compute begins only after all 2*TILE*TILE load slots have landed.
- R5: Exactly one write is made for each output element with r < W and c < W, at base_p + r*W + c. Writes never go to any other element. Writes are ordered by output tile in row-major tile order and, inside a tile, row-major.
- R6: rd_en and wr_en are never high in the same cycle.
- R7: done is high for exactly one cycle. Counting the accepting clock edge as edge 1, done is high after edge 1 + NT*NT*(NT*(2*TILE*TILE + TILE + 1) + TILE*TILE), where NT = ceil(W/TILE).
- R8: With W = 0 there are no reads and no writes, and done is high after edge 1.
- R9: A start pulse during a run is ignored. The write sequence, the values and the done timing are unchanged.
- R10: During reset done, rd_en and wr_en are low.
- R11: Accumulators are cleared at the start of every output tile, so no partial sum carries from one tile to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle; ignored otherwise |
| width_in | input | DIM_W | Matrix width W, sampled with start |
| base_m | input | ADDR_W | Base address of the left operand |
| base_n | input | ADDR_W | Base address of the right operand |
| base_p | input | ADDR_W | Base address of the product |
| rd_en | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | DATA_W | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | ACC_W | Signed product element |
| done | output | 1 | One-cycle completion pulse |

## Verification
Read data is due one cycle after each rd_en. The bench memory model registers it on the same edge the engine samples, so the engine sees the zero-filled or fetched operand exactly as the requirement states. Every cycle, at the falling edge, the bench matches each wr_en against the next entry of a queue of expected address/value pairs. That queue is computed with plain integer loops over tiles, so both order and value are checked on the cycle the write appears. Done is due a fixed number of cycles after the accepting edge, given by the formula in R7. The bench counts falling edges from that edge, checks done exactly there, and checks that it has dropped one cycle later.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_COMP  = 3'd3,
    ST_STORE = 3'd4,
    ST_DONE  = 3'd5
  } tmm_state_e;

  // number of tiles needed to cover a span
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // row-major word address of element (row,col) of a width-wide matrix
  function automatic int unsigned lin_index(input int unsigned base, input int unsigned row,
                                            input int unsigned col, input int unsigned width);
    return base + row * width + col;
  endfunction

  // position inside a width-wide square
  function automatic logic inside_square(input int unsigned row, input int unsigned col,
                                         input int unsigned width);
    return (row < width) && (col < width);
  endfunction

endpackage

// File: rtl/tmm_ctrl.sv
module tmm_ctrl
  import tmm_pkg::*;
#(
  parameter int TILE   = 4,
  parameter int DIM_W  = 6,
  parameter int ADDR_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [DIM_W-1:0]              width_in,
  input  logic [ADDR_W-1:0]             base_m,
  input  logic [ADDR_W-1:0]             base_n,
  input  logic [ADDR_W-1:0]             base_p,
  output logic                          rd_en,
  output logic [ADDR_W-1:0]             rd_addr,
  output logic                          wr_en,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic                          ld_fire,
  output logic                          ld_right,
  output logic [$clog2(TILE*TILE)-1:0]  ld_idx,
  output logic                          ld_zero,
  output logic                          comp_en,
  output logic [$clog2(TILE)-1:0]       comp_k,
  output logic                          acc_clr,
  output logic [$clog2(TILE*TILE)-1:0]  st_idx,
  output logic                          done
);

  localparam int          TT     = TILE * TILE;
  localparam int          EIDX_W = $clog2(TT);
  localparam int          KW     = $clog2(TILE);
  localparam int          CNT_W  = $clog2(2 * TT);
  localparam int unsigned TT_U   = TT;
  localparam int unsigned TILE_U = TILE;

  tmm_state_e         state_q;
  logic [DIM_W-1:0]   w_q, nt_q, tr_q, tc_q, ph_q;
  logic [ADDR_W-1:0]  bm_q, bn_q, bp_q;
  logic [CNT_W-1:0]   cnt_q;

  int unsigned w_i, e_i, ey_i, ex_i, row_i, col_i, base_i, srow_i, scol_i;
  logic        side_r, src_ok, dst_ok;

  // slot decode: first TT load slots fill the left tile, the next TT the right one
  always_comb begin
    w_i    = 32'(w_q);
    side_r = (cnt_q >= CNT_W'(TT));
    e_i    = side_r ? (32'(cnt_q) - TT_U) : 32'(cnt_q);
    ey_i   = e_i / TILE_U;
    ex_i   = e_i % TILE_U;
    if (side_r) begin
      row_i  = 32'(ph_q) * TILE_U + ey_i;
      col_i  = 32'(tc_q) * TILE_U + ex_i;
      base_i = 32'(bn_q);
    end else begin
      row_i  = 32'(tr_q) * TILE_U + ey_i;
      col_i  = 32'(ph_q) * TILE_U + ex_i;
      base_i = 32'(bm_q);
    end
    src_ok = inside_square(row_i, col_i, w_i);
    srow_i = 32'(tr_q) * TILE_U + ey_i;
    scol_i = 32'(tc_q) * TILE_U + ex_i;
    dst_ok = inside_square(srow_i, scol_i, w_i);
  end

  assign rd_en    = (state_q == ST_LOAD) && src_ok;
  assign rd_addr  = ADDR_W'(lin_index(base_i, row_i, col_i, w_i));
  assign ld_fire  = (state_q == ST_LOAD);
  assign ld_right = side_r;
  assign ld_idx   = EIDX_W'(e_i);
  assign ld_zero  = !src_ok;
  assign comp_en  = (state_q == ST_COMP);
  assign comp_k   = KW'(cnt_q);
  assign acc_clr  = (state_q == ST_LOAD) && (ph_q == '0) && (cnt_q == '0);
  assign wr_en    = (state_q == ST_STORE) && dst_ok;
  assign wr_addr  = ADDR_W'(lin_index(32'(bp_q), srow_i, scol_i, w_i));
  assign st_idx   = EIDX_W'(cnt_q);
  assign done     = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      w_q     <= '0;
      nt_q    <= '0;
      tr_q    <= '0;
      tc_q    <= '0;
      ph_q    <= '0;
      bm_q    <= '0;
      bn_q    <= '0;
      bp_q    <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            w_q   <= width_in;
            nt_q  <= DIM_W'(ceil_div(32'(width_in), TILE_U));
            bm_q  <= base_m;
            bn_q  <= base_n;
            bp_q  <= base_p;
            tr_q  <= '0;
            tc_q  <= '0;
            ph_q  <= '0;
            cnt_q <= '0;
            state_q <= (width_in == '0) ? ST_DONE : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (cnt_q == CNT_W'(2 * TT - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_DRAIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DRAIN: state_q <= ST_COMP;
        ST_COMP: begin
          if (cnt_q == CNT_W'(TILE - 1)) begin
            cnt_q <= '0;
            if (ph_q == nt_q - 1'b1) begin
              state_q <= ST_STORE;
            end else begin
              ph_q    <= ph_q + 1'b1;
              state_q <= ST_LOAD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STORE: begin
          if (cnt_q == CNT_W'(TT - 1)) begin
            cnt_q <= '0;
            ph_q  <= '0;
            if (tc_q == nt_q - 1'b1) begin
              tc_q <= '0;
              if (tr_q == nt_q - 1'b1) begin
                state_q <= ST_DONE;
              end else begin
                tr_q    <= tr_q + 1'b1;
                state_q <= ST_LOAD;
              end
            end else begin
              tc_q    <= tc_q + 1'b1;
              state_q <= ST_LOAD;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_READ_IN_MATRIX: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((32'(rd_addr) - base_i) < w_i * w_i)); // R2

  AST_WRITE_IN_MATRIX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((32'(wr_addr) - 32'(bp_q)) < w_i * w_i)); // R5

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_DONE) |-> (!rd_en && !wr_en)); // R8

endmodule

// File: rtl/tmm_tile_buf.sv
module tmm_tile_buf #(
  parameter int TILE   = 4,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_fire,
  input  logic                          ld_right,
  input  logic [$clog2(TILE*TILE)-1:0]  ld_idx,
  input  logic                          ld_zero,
  input  logic [DATA_W-1:0]             rd_data,
  input  logic [$clog2(TILE)-1:0]       comp_k,
  output logic [TILE*DATA_W-1:0]        a_col,
  output logic [TILE*DATA_W-1:0]        b_row,
  output logic                          cap_pending
);

  localparam int TT     = TILE * TILE;
  localparam int EIDX_W = $clog2(TT);

  logic [DATA_W-1:0] lbuf [TT];
  logic [DATA_W-1:0] rbuf [TT];

  // one-cycle capture stage lines a slot up with its read data
  logic              cap_v, cap_r, cap_z;
  logic [EIDX_W-1:0] cap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_v <= 1'b0;
      cap_r <= 1'b0;
      cap_z <= 1'b0;
      cap_i <= '0;
    end else begin
      cap_v <= ld_fire;
      cap_r <= ld_right;
      cap_z <= ld_zero;
      cap_i <= ld_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TT; i++) begin
        lbuf[i] <= '0;
        rbuf[i] <= '0;
      end
    end else if (cap_v) begin
      if (cap_r) rbuf[cap_i] <= cap_z ? '0 : rd_data;
      else       lbuf[cap_i] <= cap_z ? '0 : rd_data;
    end
  end

  assign cap_pending = cap_v;

  // column k of the left tile and row k of the right tile feed the array
  for (genvar g = 0; g < TILE; g++) begin : g_sel
    assign a_col[g*DATA_W +: DATA_W] = lbuf[EIDX_W'(g * TILE) + EIDX_W'(comp_k)];
    assign b_row[g*DATA_W +: DATA_W] = rbuf[EIDX_W'(comp_k) * EIDX_W'(TILE) + EIDX_W'(g)];
  end

  AST_ZERO_FILL_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_v && cap_z && !cap_r) |=> (lbuf[$past(cap_i)] == '0)); // R3

  AST_ZERO_FILL_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_v && cap_z && cap_r) |=> (rbuf[$past(cap_i)] == '0)); // R3

endmodule

// File: rtl/tmm_mac_array.sv
module tmm_mac_array #(
  parameter int TILE   = 4,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_clr,
  input  logic                          comp_en,
  input  logic [TILE*DATA_W-1:0]        a_col,
  input  logic [TILE*DATA_W-1:0]        b_row,
  output logic [TILE*TILE*ACC_W-1:0]    acc_flat
);

  localparam int PROD_W = 2 * DATA_W;

  function automatic logic [ACC_W-1:0] mac_step(input logic [ACC_W-1:0] acc,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic signed [PROD_W-1:0] p;
    p = $signed(a) * $signed(b);
    return acc + {{(ACC_W - PROD_W){p[PROD_W-1]}}, p};
  endfunction

  for (genvar gy = 0; gy < TILE; gy++) begin : g_row
    for (genvar gx = 0; gx < TILE; gx++) begin : g_col
      logic [ACC_W-1:0] acc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (acc_clr) acc_q <= '0;
        else if (comp_en) acc_q <= mac_step(acc_q, a_col[gy*DATA_W +: DATA_W],
                                            b_row[gx*DATA_W +: DATA_W]);
      end
      assign acc_flat[(gy*TILE+gx)*ACC_W +: ACC_W] = acc_q;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_flat == '0)); // R11

endmodule

// File: rtl/tile_matmul_engine.sv
module tile_matmul_engine #(
  parameter int TILE   = 4,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int DIM_W  = 6,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  width_in,
  input  logic [ADDR_W-1:0] base_m,
  input  logic [ADDR_W-1:0] base_n,
  input  logic [ADDR_W-1:0] base_p,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ACC_W-1:0]  wr_data,
  output logic              done
);

  localparam int TT     = TILE * TILE;
  localparam int EIDX_W = $clog2(TT);
  localparam int KW     = $clog2(TILE);

  // named internal events, visible to the assertions below
  logic                   ld_fire, ld_right, ld_zero;
  logic [EIDX_W-1:0]      ld_idx, st_idx;
  logic                   comp_en, acc_clr, cap_pending;
  logic [KW-1:0]          comp_k;
  logic [TILE*DATA_W-1:0] a_col, b_row;
  logic [TT*ACC_W-1:0]    acc_flat;

  tmm_ctrl #(.TILE(TILE), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .width_in (width_in),
    .base_m   (base_m),
    .base_n   (base_n),
    .base_p   (base_p),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ld_fire  (ld_fire),
    .ld_right (ld_right),
    .ld_idx   (ld_idx),
    .ld_zero  (ld_zero),
    .comp_en  (comp_en),
    .comp_k   (comp_k),
    .acc_clr  (acc_clr),
    .st_idx   (st_idx),
    .done     (done)
  );

  tmm_tile_buf #(.TILE(TILE), .DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_fire     (ld_fire),
    .ld_right    (ld_right),
    .ld_idx      (ld_idx),
    .ld_zero     (ld_zero),
    .rd_data     (rd_data),
    .comp_k      (comp_k),
    .a_col       (a_col),
    .b_row       (b_row),
    .cap_pending (cap_pending)
  );

  tmm_mac_array #(.TILE(TILE), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_clr  (acc_clr),
    .comp_en  (comp_en),
    .a_col    (a_col),
    .b_row    (b_row),
    .acc_flat (acc_flat)
  );

  assign wr_data = acc_flat[st_idx*ACC_W +: ACC_W];

  AST_LOAD_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    comp_en |-> !cap_pending); // R4

  AST_NO_LOAD_IN_COMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
    comp_en |-> !ld_fire); // R4

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

endmodule

// File: tb/tile_matmul_engine_tb_top.sv
module tile_matmul_engine_tb_top;

  localparam int TILE = 4, DATA_W = 16, ACC_W = 40, DIM_W = 6, ADDR_W = 16;
  localparam int BM = 0, BN = 256, BP = 600;

  logic              clk, rst_n, start;
  logic [DIM_W-1:0]  width_in;
  logic [ADDR_W-1:0] base_m, base_n, base_p;
  logic              rd_en, wr_en, done;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data;
  logic [ACC_W-1:0]  wr_data;

  logic signed [DATA_W-1:0] mem [0:511];

  int          tests, fails, wd, cur_w, rd_count;
  bit          mon_on;
  int unsigned lcg;
  int          exp_addr_q[$];
  longint      exp_val_q[$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  tile_matmul_engine #(.TILE(TILE), .DATA_W(DATA_W), .ACC_W(ACC_W),
                       .DIM_W(DIM_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .width_in(width_in),
    .base_m(base_m), .base_n(base_n), .base_p(base_p),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  // memory model: one-cycle read latency
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[8:0]];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_val();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % 32'd201) - 100;
  endfunction

  // per-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_en && wr_en) check(1'b0, "R6 read and write together", 1, 0);
      if (rd_en) begin
        int a;
        a = int'(rd_addr);
        rd_count++;
        if (!((a >= BM && a < BM + cur_w * cur_w) || (a >= BN && a < BN + cur_w * cur_w)))
          check(1'b0, "R2 read outside operands", a, BM);
      end
      if (wr_en) begin
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R5 unexpected write", int'(wr_addr), -1);
        end else begin
          int     ea;
          longint ev;
          ea = exp_addr_q.pop_front();
          ev = exp_val_q.pop_front();
          check(int'(wr_addr) == ea, "R5 write address/order", int'(wr_addr), ea);
          check($signed(wr_data) == ev, "R1 R11 product value", $signed(wr_data), ev);
        end
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      tests++;
      $display("FAIL R7 watchdog expired actual=%0d expected=done", wd);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_case(input int w, input bit poke);
    int nt, exp_lat, exp_reads, cyc;
    for (int i = 0; i < 512; i++) mem[i] = DATA_W'(next_val());
    exp_addr_q.delete();
    exp_val_q.delete();
    nt = (w + TILE - 1) / TILE;
    exp_reads = 0;
    for (int tr = 0; tr < nt; tr++)
      for (int tc = 0; tc < nt; tc++) begin
        for (int ph = 0; ph < nt; ph++)
          for (int y = 0; y < TILE; y++)
            for (int x = 0; x < TILE; x++) begin
              if (tr*TILE + y < w && ph*TILE + x < w) exp_reads++;
              if (ph*TILE + y < w && tc*TILE + x < w) exp_reads++;
            end
        for (int y = 0; y < TILE; y++)
          for (int x = 0; x < TILE; x++) begin
            int r, c;
            longint s;
            r = tr*TILE + y;
            c = tc*TILE + x;
            if (r < w && c < w) begin
              s = 0;
              for (int k = 0; k < w; k++)
                s += longint'(mem[BM + r*w + k]) * longint'(mem[BN + k*w + c]);
              exp_addr_q.push_back(BP + r*w + c);
              exp_val_q.push_back(s);
            end
          end
      end
    exp_lat = 1 + nt*nt*(nt*(2*TILE*TILE + TILE + 1) + TILE*TILE);
    cur_w = w;
    rd_count = 0;
    mon_on = 1'b1;
    @(negedge clk);
    width_in = DIM_W'(w);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = (poke && (cyc == 6 || cyc == 40));
    end
    start = 1'b0;
    check(cyc == exp_lat, poke ? "R9 R7 done timing with stray start" : "R7 done timing",
          cyc, exp_lat);
    @(negedge clk);
    check(done == 1'b0, "R7 done is a single pulse", done, 0);
    mon_on = 1'b0;
    check(exp_addr_q.size() == 0, "R5 all outputs written", exp_addr_q.size(), 0);
    check(rd_count == exp_reads, w == 0 ? "R8 no reads for zero width" : "R3 read count",
          rd_count, exp_reads);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    tests = 0; fails = 0; wd = 0; lcg = 32'd7; mon_on = 1'b0;
    rst_n = 1'b0; start = 1'b0; width_in = '0;
    base_m = ADDR_W'(BM); base_n = ADDR_W'(BN); base_p = ADDR_W'(BP);
    repeat (3) @(negedge clk);
    check(!done && !rd_en && !wr_en, "R10 outputs low in reset",
          {done, rd_en, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(4, 1'b0);  // R1 exact single tile
    run_case(3, 1'b0);  // R3 width below tile
    run_case(8, 1'b0);  // R11 four output tiles
    run_case(5, 1'b0);  // R3 ragged edge
    run_case(0, 1'b0);  // R8 empty run
    run_case(1, 1'b0);  // R1 scalar
    run_case(6, 1'b1);  // R9 stray start pulses
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule